// File: doc/BRIEF.md
# Reply Pulse Spacing Error Checker

This block judges, one interrogation cycle at a time, whether the pulses of a received reply sit close enough to where they belong. A reference strobe marks each nominal pulse position. The sampled reply video supplies the actual positions through its rising edges. For every pulse the block opens an error interval that runs from whichever of the two events comes first to the one that comes second. Its length in sample clocks is therefore the spacing deviation, whether the pulse is early or late. If the partner event never arrives, the interval closes after a fixed length that stands for a missing pulse.

Each error interval starts a qualification window of fixed length on the same clock. An interval that is still open once its window has run out marks the current cycle as bad. The block holds this in a sticky error flag until the decode-enable pulse that opens the next cycle. Intervals that begin while the first framing pulse is being received are measured but never qualified. Decoding of the pulse train and any judgement across many cycles are left to neighbouring blocks.

Top module: `reply_spacing_checker`

## Requirements
- R1: The first of a reference strobe or a video rising edge starts an interval, and `err_span` is high from the next cycle for exactly as many cycles as the second event lags the first. A strobe and an edge sampled on the same clock while idle open no interval.
- R2: When the partner event has not arrived, `err_span` drops after MISS_CNT (default 50) high cycles.
- R3: `qual_win` rises together with `err_span` and stays high for WIN_CNT (default 35) cycles, even when the interval is shorter.
- R4: An interval of WIN_CNT cycles or fewer (including 15, 34 and 35) leaves `cycle_err` low.
- R5: An interval of at least WIN_CNT+1 cycles sets `cycle_err` on the clock edge that ends its (WIN_CNT+1)-th high cycle.
- R6: `cycle_err` stays set until `cycle_start` is sampled high. That clock clears the flag and ends any open interval and window. Clearing takes priority over setting.
- R7: An interval that starts on a clock where `first_frame` is high never sets `cycle_err`, whatever its length.
- R8: A video rising edge is a sample at 1 after a sample at 0. While an interval is open, a repeat of the event that opened it is ignored.
- R9: While `rst_n` is low, `err_span`, `qual_win` and `cycle_err` are low. Reset is asserted asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Decode-enable pulse opening an interrogation cycle |
| ref_strobe | input | 1 | One-cycle mark of a nominal pulse position |
| video | input | 1 | Sampled reply video |
| first_frame | input | 1 | High during the first framing pulse time |
| err_span | output | 1 | Error interval in progress |
| qual_win | output | 1 | Qualification window in progress |
| cycle_err | output | 1 | Sticky error flag for the current cycle |

## Verification
The spacing measure is driven with late pulses and early pulses of several deviations, including 34, 35 and 36 counts. This separates a correct start and end pairing from an off-by-one at the window edge. Coincident events, a missing pulse and a video level that is already high show whether the missing length is applied and whether edge detection, not level, ends an interval. Extra strobes, an interval that begins during the first framing pulse and a decode-enable pulse in mid-interval test the ignore, inhibit and clear priorities. One case places the exact clock on which the flag rises.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    SPAN_IDLE  = 2'd0,
    SPAN_EARLY = 2'd1,
    SPAN_LATE  = 2'd2
  } span_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rps_edge_detect.sv
module rps_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic video,
  output logic rise
);
  logic video_q;
  logic video_d;

  always_comb begin
    video_d = video;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) video_q <= 1'b0;
    else        video_q <= video_d;
  end

  assign rise = video & ~video_q;
endmodule

// File: rtl/rps_interval.sv
module rps_interval #(
  parameter int unsigned MISS_CNT = 50,
  parameter int unsigned CNT_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic rise,
  input  logic inh_in,
  output logic span,
  output logic span_start,
  output logic span_inh
);
  import rps_pkg::*;

  localparam logic [CNT_W-1:0] MISS_L = CNT_W'(MISS_CNT);
  localparam logic [CNT_W-1:0] ONE_L  = CNT_W'(1);

  span_state_e state_q, state_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic inh_q, inh_d;
  logic start_c;

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    inh_d   = inh_q;
    start_c = 1'b0;
    if (clr) begin
      state_d = SPAN_IDLE;
      len_d   = '0;
      inh_d   = 1'b0;
    end else begin
      unique case (state_q)
        SPAN_IDLE: begin
          if (strobe ^ rise) begin
            state_d = strobe ? SPAN_LATE : SPAN_EARLY;
            len_d   = ONE_L;
            inh_d   = inh_in;
            start_c = 1'b1;
          end
        end
        SPAN_EARLY: begin
          if (strobe || len_q == MISS_L) state_d = SPAN_IDLE;
          else                           len_d   = len_q + ONE_L;
        end
        SPAN_LATE: begin
          if (rise || len_q == MISS_L) state_d = SPAN_IDLE;
          else                         len_d   = len_q + ONE_L;
        end
        default: state_d = SPAN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPAN_IDLE;
      len_q   <= '0;
      inh_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      inh_q   <= inh_d;
    end
  end

  assign span       = (state_q != SPAN_IDLE);
  assign span_start = start_c;
  assign span_inh   = inh_q;

  assert_span_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    span |-> (len_q <= MISS_L));

  assert_span_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(span) |-> $past(strobe ^ rise));

  assert_clr_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !span);
endmodule

// File: rtl/rps_qual_window.sv
module rps_qual_window #(
  parameter int unsigned WIN_CNT = 35,
  parameter int unsigned CNT_W   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic win
);
  localparam logic [CNT_W-1:0] WIN_L = CNT_W'(WIN_CNT);
  localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

  logic win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (clr) begin
      win_d = 1'b0;
      cnt_d = '0;
    end else if (start) begin
      win_d = 1'b1;
      cnt_d = ONE_L;
    end else if (win_q) begin
      if (cnt_q == WIN_L) win_d = 1'b0;
      else                cnt_d = cnt_q + ONE_L;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign win = win_q;

  assert_win_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr) |=> win);

  assert_win_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win) |-> ($past(cnt_q) == WIN_L || $past(clr)));
endmodule

// File: rtl/reply_spacing_checker.sv
module reply_spacing_checker #(
  parameter int unsigned WIN_CNT  = 35,
  parameter int unsigned MISS_CNT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic ref_strobe,
  input  logic video,
  input  logic first_frame,
  output logic err_span,
  output logic qual_win,
  output logic cycle_err
);
  localparam int unsigned MAX_CNT = rps_pkg::max_u(WIN_CNT, MISS_CNT);
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic rst_meta_q, rst_sync_q;
  logic rise;
  logic span, span_start, span_inh, win;
  logic overrun;
  logic err_q, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rps_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .video (video),
    .rise  (rise)
  );

  rps_interval #(.MISS_CNT(MISS_CNT), .CNT_W(CNT_W)) u_span (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .clr        (cycle_start),
    .strobe     (ref_strobe),
    .rise       (rise),
    .inh_in     (first_frame),
    .span       (span),
    .span_start (span_start),
    .span_inh   (span_inh)
  );

  rps_qual_window #(.WIN_CNT(WIN_CNT), .CNT_W(CNT_W)) u_win (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (cycle_start),
    .start (span_start),
    .win   (win)
  );

  assign overrun = span & ~win & ~span_inh;

  always_comb begin
    if (cycle_start) err_d = 1'b0;
    else             err_d = err_q | overrun;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign err_span  = span;
  assign qual_win  = win;
  assign cycle_err = err_q;

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cycle_start |=> !cycle_err);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cycle_err && !cycle_start) |=> cycle_err);

  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(cycle_err) |-> $past(span && !win));

  assert_flag_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(cycle_err) |-> $past(!span_inh));
endmodule

// File: tb/reply_spacing_checker_test.sv
module reply_spacing_checker_test;
  localparam int WIN  = 35;
  localparam int MISS = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_start = 1'b0;
  logic ref_strobe = 1'b0;
  logic video = 1'b0;
  logic first_frame = 1'b0;
  logic err_span, qual_win, cycle_err;

  int checks = 0;
  int fails  = 0;
  int exp_span[$];
  int exp_win[$];
  int span_run = 0;
  int win_run  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reply_spacing_checker #(.WIN_CNT(WIN), .MISS_CNT(MISS)) uut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .ref_strobe(ref_strobe), .video(video), .first_frame(first_frame),
    .err_span(err_span), .qual_win(qual_win), .cycle_err(cycle_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures every err_span and qual_win pulse and pops the expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (err_span) span_run++;
      else if (span_run > 0) begin
        if (exp_span.size() == 0) chk(0, "R1 unexpected err_span pulse", span_run, 0);
        else begin
          int e;
          e = exp_span.pop_front();
          chk(span_run == e, "R1/R2 err_span length", span_run, e);
        end
        span_run = 0;
      end
      if (qual_win) win_run++;
      else if (win_run > 0) begin
        if (exp_win.size() == 0) chk(0, "R3 unexpected qual_win pulse", win_run, 0);
        else begin
          int e;
          e = exp_win.pop_front();
          chk(win_run == e, "R3 qual_win length", win_run, e);
        end
        win_run = 0;
      end
    end
  end

  task automatic expect_pulse(input int len, input int wlen);
    exp_span.push_back(len);
    exp_win.push_back(wlen);
  endtask

  // first event now, partner event d clocks later; d = 0 means coincident
  task automatic pair(input int d, input bit early, input bit inh);
    if (d == 0) begin
      ref_strobe = 1'b1; video = 1'b1;
    end else if (early) video = 1'b1;
    else ref_strobe = 1'b1;
    first_frame = inh;
    @(negedge clk);
    ref_strobe = 1'b0; first_frame = 1'b0;
    if (d > 0) begin
      repeat (d - 1) @(negedge clk);
      if (early) ref_strobe = 1'b1;
      else video = 1'b1;
      @(negedge clk);
      ref_strobe = 1'b0;
    end
    repeat (3) @(negedge clk);
    video = 1'b0;
  endtask

  task automatic close_case(input bit exp_flag, input string req);
    repeat (60) @(negedge clk);
    chk(cycle_err == exp_flag, req, cycle_err, exp_flag);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    chk(cycle_err == 1'b0, "R6 flag cleared by cycle_start", cycle_err, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(err_span == 1'b0, "R9 err_span in reset", err_span, 0);
    chk(qual_win == 1'b0, "R9 qual_win in reset", qual_win, 0);
    chk(cycle_err == 1'b0, "R9 cycle_err in reset", cycle_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 late and early pulses, accepted deviations
    expect_pulse(10, WIN); pair(10, 0, 0); close_case(0, "R4 late 10 accepted");
    expect_pulse(12, WIN); pair(12, 1, 0); close_case(0, "R1 early 12 accepted");
    expect_pulse(15, WIN); pair(15, 0, 0); close_case(0, "R4 late 15 accepted");
    // R4 / R5 window boundary
    expect_pulse(34, WIN); pair(34, 0, 0); close_case(0, "R4 deviation 34 accepted");
    expect_pulse(35, WIN); pair(35, 1, 0); close_case(0, "R4 deviation 35 accepted");
    expect_pulse(36, WIN); pair(36, 0, 0); close_case(1, "R5 deviation 36 rejected");
    expect_pulse(36, WIN); pair(36, 1, 0); close_case(1, "R5 early 36 rejected");
    // R1 coincident events open nothing
    pair(0, 0, 0); close_case(0, "R1 coincident no error");

    // R2 missing pulse, R6 stickiness
    expect_pulse(MISS, WIN);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (100) @(negedge clk);
    chk(cycle_err == 1'b1, "R6 flag still held long after interval", cycle_err, 1);
    close_case(1, "R2 missing pulse rejected");

    // R5 exact set clock with deviation 40
    expect_pulse(40, WIN);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (35) @(negedge clk);
    chk(cycle_err == 1'b0, "R5 flag low before 36th cycle ends", cycle_err, 0);
    @(negedge clk);
    chk(cycle_err == 1'b1, "R5 flag set at end of 36th cycle", cycle_err, 1);
    repeat (3) @(negedge clk);
    video = 1'b1; repeat (3) @(negedge clk); video = 1'b0;
    close_case(1, "R5 deviation 40 rejected");

    // R7 inhibited interval never qualifies
    expect_pulse(MISS, WIN);
    first_frame = 1'b1; ref_strobe = 1'b1; @(negedge clk);
    first_frame = 1'b0; ref_strobe = 1'b0;
    close_case(0, "R7 first frame interval inhibited");

    // R8 repeated strobe ignored while waiting for the edge
    expect_pulse(20, WIN);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (4) @(negedge clk);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (14) @(negedge clk);
    video = 1'b1; repeat (3) @(negedge clk); video = 1'b0;
    close_case(0, "R8 repeated strobe ignored");

    // R8 a level that is already high is no edge
    expect_pulse(3, WIN);
    expect_pulse(MISS, WIN);
    video = 1'b1; @(negedge clk);
    repeat (2) @(negedge clk);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (39) @(negedge clk);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (60) @(negedge clk);
    video = 1'b0;
    close_case(1, "R8 held video gives missing pulse");

    // R6 cycle_start ends an open interval and window
    expect_pulse(10, 10);
    ref_strobe = 1'b1; @(negedge clk); ref_strobe = 1'b0;
    repeat (9) @(negedge clk);
    cycle_start = 1'b1; @(negedge clk); cycle_start = 1'b0;
    chk(err_span == 1'b0, "R6 interval ended by cycle_start", err_span, 0);
    chk(qual_win == 1'b0, "R6 window ended by cycle_start", qual_win, 0);
    close_case(0, "R6 aborted interval no error");

    repeat (5) @(negedge clk);
    chk(exp_span.size() == 0, "R1 all expected intervals seen", exp_span.size(), 0);
    chk(exp_win.size() == 0, "R3 all expected windows seen", exp_win.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule